// File: doc/BRIEF.md
# Bit-Serial Threshold-Masked Ripple Adder

This block adds two operands modulo 2^W (W = 32 by default) while both the operands and the sum stay split into three Boolean shares: the value of a word is the XOR of its three shares. The datapath never recombines shares. Each share of each operand is loaded into its own shift register and scanned from the least significant bit upward, two bits per pair of clock cycles. The shared carry is formed by three component functions. Each of them reads only two of the three input shares. Their outputs always land in a register before anything uses them.

Two carry-function instances take turns. One instance reads the even carry register and writes the odd carry register. The other reads the odd register and writes the even one. Each register is written only on its own phase, so no carry function ever feeds its own output back into its input within one cycle. Four fresh random bits, taken with the start pulse, set both carry registers to random sharings of zero. The addition then consumes no further randomness. The sum shares are shifted back into the operand-a registers and appear on the result ports. A single-cycle done flag marks when the result is complete.

Top module: `tm_ripple_adder`

## Requirements
- R1: When done is high, sum_sh0 ^ sum_sh1 ^ sum_sh2 equals (A + B) mod 2^W, where A = a_sh0 ^ a_sh1 ^ a_sh2 and B = b_sh0 ^ b_sh1 ^ b_sh2 are the values present when start was accepted.
- R2: A start pulse is accepted on a clock edge only when the block is idle. Done is high in the cycle that begins W clock edges after the accepting edge, counting the accepting edge as edge 0.
- R3: Done is high for exactly one cycle per addition.
- R4: A start pulse that arrives during an addition is ignored: the running result and its timing are unchanged.
- R5: The two carry registers are written on alternating cycles: even-phase cycles (phase 0) write only the odd carry register, and odd-phase cycles (phase 1) write only the even carry register. The operand registers shift by two bits on phase-1 cycles only.
- R6: On an accepted start, the even carry register is loaded with (fresh[0], fresh[1], fresh[0]^fresh[1]) and the odd register with (fresh[2], fresh[3], fresh[2]^fresh[3]), so that each holds a sharing of zero.
- R7: The recombined result depends only on A and B. It does not depend on how the operands are split into shares or on the fresh bits.
- R8: The carry out of bit W-1 is discarded, so sums that overflow wrap modulo 2^W.
- R9: Carry output share j does not depend on input share j of a, b or the carry. The XOR of the three output shares equals the majority of the recombined a, b and carry bits.
- R10: While idle, the result shares hold their value until the next accepted start.
- R11: After reset, done is low and all result shares are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, sampled when idle |
| a_sh0 | input | W | Operand a, share 0 |
| a_sh1 | input | W | Operand a, share 1 |
| a_sh2 | input | W | Operand a, share 2 |
| b_sh0 | input | W | Operand b, share 0 |
| b_sh1 | input | W | Operand b, share 1 |
| b_sh2 | input | W | Operand b, share 2 |
| fresh | input | 4 | Fresh random bits used to initialise the carry sharings |
| sum_sh0 | output | W | Result, share 0 |
| sum_sh1 | output | W | Result, share 1 |
| sum_sh2 | output | W | Result, share 2 |
| done | output | 1 | One-cycle flag: the result is complete |

## Verification
The assertions check four things on every cycle. The carry registers never change on the same cycle, and the shift happens only on alternate cycles. A freshly loaded carry recombines to zero. Done lasts one cycle and follows the final shift. The result shares stay frozen while idle. Only the bench scenarios can show the arithmetic itself: correct wrapped sums across many operand values and share splits, exact latency, that a start pulse during a run is ignored, and the non-completeness and correctness of the carry sharing. The bench checks that last point over all 512 share inputs.

// File: rtl/tmadd_pkg.sv
package tmadd_pkg;

  localparam int NSH = 3;

  typedef logic [NSH-1:0] shr_t;

  // One carry component over input shares p and q only
  function automatic logic carry_part(input logic ap, input logic aq,
                                      input logic bp, input logic bq,
                                      input logic cp, input logic cq);
    return (ap & bp) ^ (ap & bq) ^ (aq & bp) ^
           (ap & cp) ^ (ap & cq) ^ (aq & cp) ^
           (bp & cp) ^ (bp & cq) ^ (bq & cp);
  endfunction

  // Shared majority: output share j never reads input share j
  function automatic shr_t carry_shared(input shr_t a, input shr_t b, input shr_t c);
    shr_t r;
    r[0] = carry_part(a[1], a[2], b[1], b[2], c[1], c[2]);
    r[1] = carry_part(a[2], a[0], b[2], b[0], c[2], c[0]);
    r[2] = carry_part(a[0], a[1], b[0], b[1], c[0], c[1]);
    return r;
  endfunction

  // Zero sharing built from two random bits
  function automatic shr_t zero_share(input logic r0, input logic r1);
    return {r0 ^ r1, r1, r0};
  endfunction

endpackage

// File: rtl/tm_carry_fn.sv
module tm_carry_fn
  import tmadd_pkg::*;
(
  input  shr_t a_bit,
  input  shr_t b_bit,
  input  shr_t c_in,
  output shr_t c_out
);

  assign c_out = carry_shared(a_bit, b_bit, c_in);

endmodule

// File: rtl/tm_share_lane.sv
module tm_share_lane #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] a_load,
  input  logic [W-1:0] b_load,
  input  logic [1:0]   sum_in,
  output logic [W-1:0] a_q,
  output logic [1:0]   b_lo
);

  logic [W-1:0] b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load) begin
      a_q <= a_load;
      b_q <= b_load;
    end else if (shift) begin
      a_q <= {sum_in, a_q[W-1:2]};
      b_q <= {2'b00, b_q[W-1:2]};
    end
  end

  assign b_lo = b_q[1:0];

endmodule

// File: rtl/tm_ripple_adder.sv
module tm_ripple_adder
  import tmadd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a_sh0,
  input  logic [W-1:0] a_sh1,
  input  logic [W-1:0] a_sh2,
  input  logic [W-1:0] b_sh0,
  input  logic [W-1:0] b_sh1,
  input  logic [W-1:0] b_sh2,
  input  logic [3:0]   fresh,
  output logic [W-1:0] sum_sh0,
  output logic [W-1:0] sum_sh1,
  output logic [W-1:0] sum_sh2,
  output logic         done
);

  localparam int PAIRS = W / 2;
  localparam int CW    = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic          busy_q, ph_q, done_q;
  logic [CW-1:0] pair_q;
  shr_t          car_q [2];
  shr_t          car_nx [2];
  shr_t          a_bit [2];
  shr_t          b_bit [2];
  shr_t          sum_bit [2];
  logic [W-1:0]  a_in [NSH];
  logic [W-1:0]  b_in [NSH];
  logic [W-1:0]  res_q [NSH];
  logic [1:0]    b_lo [NSH];

  // Named events for the checks
  logic start_acc, step_odd, pair_step, last_step;
  assign start_acc = start & ~busy_q;
  assign step_odd  = busy_q & ~ph_q;
  assign pair_step = busy_q & ph_q;
  assign last_step = pair_step & (pair_q == CW'(PAIRS - 1));

  assign a_in[0] = a_sh0;  assign a_in[1] = a_sh1;  assign a_in[2] = a_sh2;
  assign b_in[0] = b_sh0;  assign b_in[1] = b_sh1;  assign b_in[2] = b_sh2;

  genvar j, k;
  generate
    for (j = 0; j < NSH; j++) begin : g_lane
      tm_share_lane #(.W(W)) i_lane (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start_acc),
        .shift  (pair_step),
        .a_load (a_in[j]),
        .b_load (b_in[j]),
        .sum_in ({sum_bit[1][j], sum_bit[0][j]}),
        .a_q    (res_q[j]),
        .b_lo   (b_lo[j])
      );
      for (k = 0; k < 2; k++) begin : g_bits
        assign a_bit[k][j] = res_q[j][k];
        assign b_bit[k][j] = b_lo[j][k];
      end
    end

    // Instance k reads carry register k and bit k of the pair and writes register 1-k
    for (k = 0; k < 2; k++) begin : g_carry
      tm_carry_fn i_cf (
        .a_bit (a_bit[k]),
        .b_bit (b_bit[k]),
        .c_in  (car_q[k]),
        .c_out (car_nx[k])
      );
      assign sum_bit[k] = a_bit[k] ^ b_bit[k] ^ car_q[k];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_q[0] <= '0;
      car_q[1] <= '0;
    end else if (start_acc) begin
      car_q[0] <= zero_share(fresh[0], fresh[1]);
      car_q[1] <= zero_share(fresh[2], fresh[3]);
    end else if (step_odd) begin
      car_q[1] <= car_nx[0];
    end else if (pair_step) begin
      car_q[0] <= car_nx[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      pair_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_step;
      if (start_acc) begin
        busy_q <= 1'b1;
        ph_q   <= 1'b0;
        pair_q <= '0;
      end else if (busy_q) begin
        ph_q <= ~ph_q;
        if (pair_step) pair_q <= pair_q + CW'(1);
        if (last_step) busy_q <= 1'b0;
      end
    end
  end

  assign sum_sh0 = res_q[0];
  assign sum_sh1 = res_q[1];
  assign sum_sh2 = res_q[2];
  assign done    = done_q;

  AST_EVEN_CARRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    step_odd |=> $stable(car_q[0])); // R5
  AST_ODD_CARRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pair_step |=> $stable(car_q[1])); // R5
  AST_SHIFT_PACE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_step |=> !pair_step); // R5
  AST_CARRY_ZERO_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> ((^car_q[0]) == 1'b0) && ((^car_q[1]) == 1'b0)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R3
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(last_step)); // R2
  AST_IDLE_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_acc) |=> ($stable(res_q[0]) && $stable(res_q[1]) && $stable(res_q[2]))); // R10

endmodule

// File: tb/test_tm_ripple_adder.sv
`timescale 1ns/100ps
module test_tm_ripple_adder;
  import tmadd_pkg::*;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] a0 = '0, a1 = '0, a2 = '0, b0 = '0, b1 = '0, b2 = '0;
  logic [3:0]   fresh = '0;
  logic [W-1:0] s0, s1, s2;
  logic         done;

  int tests = 0;
  int fails = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  tm_ripple_adder #(.W(W)) i_tm_ripple_adder (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_sh0(a0), .a_sh1(a1), .a_sh2(a2),
    .b_sh0(b0), .b_sh1(b1), .b_sh2(b2),
    .fresh(fresh),
    .sum_sh0(s0), .sum_sh1(s1), .sum_sh2(s2), .done(done));

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic nextr(output logic [31:0] v);
    rng = xs(rng);
    v = rng;
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one addition; optionally pulses start mid-run with other operands
  task automatic run_add(input logic [W-1:0] av, input logic [W-1:0] bv, input bit interfere);
    logic [31:0] m1, m2, m3, m4, f;
    logic [W-1:0] expv, got;
    int cnt;
    nextr(m1); nextr(m2); nextr(m3); nextr(m4); nextr(f);
    @(negedge clk);
    a0 = m1; a1 = m2; a2 = av ^ m1 ^ m2;
    b0 = m3; b1 = m4; b2 = bv ^ m3 ^ m4;
    fresh = f[3:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    while (!done && cnt < 200) begin
      if (interfere && cnt == 9) begin
        a0 = ~a0; b2 = b2 ^ 32'h5A5A_0F0F; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    expv = av + bv;
    got = s0 ^ s1 ^ s2;
    check(cnt == W + 1, interfere ? "R4 latency" : "R2 latency", 64'(cnt), 64'(W + 1));
    check(got == expv, interfere ? "R4 result" : "R1 result", 64'(got), 64'(expv));
    @(negedge clk);
    check(done == 1'b0, "R3 done width", 64'(done), 64'd0);
  endtask

  initial begin
    #(100000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] ra, rb;
    logic [W-1:0] hold0, hold1, hold2;
    bit nc_ok, maj_ok;
    // R9: exhaustive over all share inputs of one carry function
    nc_ok = 1'b1; maj_ok = 1'b1;
    for (int v = 0; v < 512; v++) begin
      shr_t aa, bb, cc, r, rt;
      aa = v[2:0]; bb = v[5:3]; cc = v[8:6];
      r = carry_shared(aa, bb, cc);
      if ((^r) != (((^aa) & (^bb)) | ((^aa) & (^cc)) | ((^bb) & (^cc)))) maj_ok = 1'b0;
      for (int j = 0; j < 3; j++) begin
        shr_t m;
        m = shr_t'(1 << j);
        rt = carry_shared(aa ^ m, bb ^ m, cc ^ m);
        if (rt[j] != r[j]) nc_ok = 1'b0;
      end
    end
    check(nc_ok, "R9 non-completeness", 64'(nc_ok), 64'd1);
    check(maj_ok, "R9 carry correctness", 64'(maj_ok), 64'd1);

    repeat (3) @(negedge clk);
    check(done == 1'b0, "R11 reset done", 64'(done), 64'd0);
    check((s0 | s1 | s2) == '0, "R11 reset result", 64'(s0 | s1 | s2), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_add(32'h0, 32'h0, 1'b0);
    run_add(32'hFFFF_FFFF, 32'h1, 1'b0);          // R8 wrap to zero
    run_add(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);  // R8
    run_add(32'h8000_0000, 32'h8000_0000, 1'b0);  // R8 top carry dropped
    run_add(32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
    run_add(32'h5555_5555, 32'h5555_5555, 1'b0);
    run_add(32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
    // R7: same operands under several share splits and fresh bits
    for (int r = 0; r < 6; r++) run_add(32'hDEAD_BEEF, 32'h0123_4567, 1'b0);
    // R4: start pulse mid-run
    run_add(32'h1357_9BDF, 32'h2468_ACE0, 1'b1);
    run_add(32'hFFFF_0000, 32'h0001_FFFF, 1'b1);
    for (int r = 0; r < 40; r++) begin
      nextr(ra); nextr(rb);
      run_add(ra, rb, 1'b0);
    end

    // R10: idle result held while inputs change without start
    hold0 = s0; hold1 = s1; hold2 = s2;
    @(negedge clk);
    a0 = ~a0; b1 = ~b1; fresh = ~fresh;
    repeat (6) @(negedge clk);
    check({s0, s1, s2} == {hold0, hold1, hold2}, "R10 idle hold",
          64'(s0 ^ s1 ^ s2), 64'(hold0 ^ hold1 ^ hold2));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule